// File: doc/BRIEF.md
# Accumulator ALU with Carry Flag and Branch Condition Unit

This block is the arithmetic core of a small 8-bit processor. It holds an accumulator and a one-bit carry flag. When a 3-bit function code and an 8-bit memory operand are presented with `op_valid`, it updates both registers at the next rising clock edge. The functions are load, OR, AND, XOR, add, and two reverse subtracts: operand minus accumulator, and accumulator minus operand. There is also a logical shift right of the accumulator. Both subtracts are formed by two's-complement addition on one shared adder. The carry out of that adder becomes the new flag, so a flag of 1 after a subtract means no borrow occurred. Only add, the subtracts and the shift touch the flag.

The same block decodes the condition of the short-branch opcode group. A 4-bit condition code selects one test against the current accumulator, the carry flag, or one of four external flag inputs. The answer appears on `br_taken` in the same cycle. A taken short branch replaces only the low byte of the program counter, so its target stays within the current 256-byte page. Building that address, fetching the operand and updating pointers is done outside this block. Immediate-operand opcodes map onto the same 3-bit function codes; choosing where the operand comes from is done outside as well.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, `acc` reads 0 and `carry` reads 0. Reset is asserted asynchronously and released synchronously. In any cycle with `op_valid` low, `acc` and `carry` keep their values.
- R2: Function 0 (load) sets `acc` to `operand` and leaves `carry` unchanged.
- R3: Functions 1, 2 and 3 set `acc` to `acc` OR, AND, or XOR `operand`, respectively, and leave `carry` unchanged.
- R4: Function 4 (add) sets `{carry, acc}` to the 9-bit sum `acc + operand`.
- R5: Function 5 sets `acc` to `operand + ~acc + 1` (operand minus accumulator). `carry` takes the carry out of that sum, so 1 means no borrow.
- R6: Function 7 sets `acc` to `acc + ~operand + 1` (accumulator minus operand). `carry` takes the carry out of that sum.
- R7: Function 6 shifts `acc` right by one place. A 0 enters the MSB, the old LSB goes to `carry`, and `operand` has no effect.
- R8: Condition code 0 makes `br_taken` 1. Codes 1 and 8 make it 0 whatever the state.
- R9: Code 2 is taken when `acc` is 0. Code A is taken when `acc` is not 0.
- R10: Code 3 is taken when `carry` is 1. Code B is taken when `carry` is 0.
- R11: Codes 4, 5, 6 and 7 are taken when `ext_flag[0]`, `[1]`, `[2]` and `[3]` is 1, respectively. Codes C, D, E and F are taken when the same bit is 0.
- R12: `br_taken` depends combinationally on `br_code`, `ext_flag` and the registered `acc` and `carry`. It therefore follows an accumulator or flag update in the cycle after the update edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Execute `alu_fn` at this edge |
| alu_fn | input | 3 | Function code 0 to 7 |
| operand | input | 8 | Memory or immediate byte |
| br_code | input | 4 | Short-branch condition code |
| ext_flag | input | 4 | External test flags |
| acc | output | 8 | Accumulator |
| carry | output | 1 | Carry flag |
| br_taken | output | 1 | Branch condition result |

## Verification
An operation presented with `op_valid` takes effect at one rising edge and is visible after it. The driver therefore queues one expected accumulator/flag pair for every driven cycle, including idle ones. The monitor pops each pair 5 ns after the following rising edge. The branch decision has no register in its path, so each condition is compared 2 ns after its inputs change, against the accumulator and flag already held in the registers. Carry cases are chosen so that each subtract is covered both with and without a borrow, and an add is covered with and without overflow.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;
  typedef enum logic [2:0] {
    FN_LOAD = 3'd0,
    FN_OR   = 3'd1,
    FN_AND  = 3'd2,
    FN_XOR  = 3'd3,
    FN_ADD  = 3'd4,
    FN_RSUB = 3'd5,
    FN_SHR  = 3'd6,
    FN_SUB  = 3'd7
  } alu_fn_e;

  localparam int FLAG_W = 4;
endpackage

// File: rtl/acc_alu_rst_sync.sv
`timescale 1ns/1ps
module acc_alu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/acc_alu_adder.sv
`timescale 1ns/1ps
module acc_alu_adder #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] sum,
  output logic          cout
);
  logic [DW:0] c;
  assign c[0] = cin;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign sum[i]  = a[i] ^ b[i] ^ c[i];
    assign c[i+1]  = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
  end

  assign cout = c[DW];
endmodule

// File: rtl/acc_alu_exec.sv
`timescale 1ns/1ps
module acc_alu_exec
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [2:0]    fn,
  input  logic [DW-1:0] d_in,
  input  logic [DW-1:0] m_in,
  input  logic          c_in,
  output logic [DW-1:0] d_out,
  output logic          c_out
);
  logic [DW-1:0] add_a, add_b, add_s;
  logic          add_ci, add_co;
  alu_fn_e       f;

  assign f = alu_fn_e'(fn);

  // One adder serves add and both subtract directions.
  always_comb begin
    add_a  = d_in;
    add_b  = m_in;
    add_ci = 1'b0;
    unique case (f)
      FN_RSUB: begin add_a = m_in; add_b = ~d_in; add_ci = 1'b1; end
      FN_SUB:  begin add_a = d_in; add_b = ~m_in; add_ci = 1'b1; end
      default: ;
    endcase
  end

  acc_alu_adder #(.DW(DW)) u_add (
    .a(add_a), .b(add_b), .cin(add_ci), .sum(add_s), .cout(add_co)
  );

  always_comb begin
    d_out = d_in;
    c_out = c_in;
    unique case (f)
      FN_LOAD: d_out = m_in;
      FN_OR:   d_out = d_in | m_in;
      FN_AND:  d_out = d_in & m_in;
      FN_XOR:  d_out = d_in ^ m_in;
      FN_ADD, FN_RSUB, FN_SUB: begin
        d_out = add_s;
        c_out = add_co;
      end
      FN_SHR: begin
        d_out = {1'b0, d_in[DW-1:1]};
        c_out = d_in[0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu_cond.sv
`timescale 1ns/1ps
module acc_alu_cond
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [3:0]        code,
  input  logic [DW-1:0]     d,
  input  logic              c,
  input  logic [FLAG_W-1:0] flags,
  output logic              taken
);
  logic d_zero, flag_sel;

  assign d_zero   = ~|d;
  assign flag_sel = flags[code[1:0]];

  always_comb begin
    unique case (code)
      4'h0:                      taken = 1'b1;
      4'h2:                      taken = d_zero;
      4'h3:                      taken = c;
      4'h4, 4'h5, 4'h6, 4'h7:    taken = flag_sel;
      4'hA:                      taken = ~d_zero;
      4'hB:                      taken = ~c;
      4'hC, 4'hD, 4'hE, 4'hF:    taken = ~flag_sel;
      default:                   taken = 1'b0;  // 1 and 8: never
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        alu_fn,
  input  logic [DW-1:0]     operand,
  input  logic [3:0]        br_code,
  input  logic [FLAG_W-1:0] ext_flag,
  output logic [DW-1:0]     acc,
  output logic              carry,
  output logic              br_taken
);
  logic          rst_n_sync;
  logic [DW-1:0] acc_q, acc_nxt, exec_d;
  logic          c_q, c_nxt, exec_c;

  acc_alu_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  acc_alu_exec #(.DW(DW)) u_exec (
    .fn(alu_fn), .d_in(acc_q), .m_in(operand), .c_in(c_q),
    .d_out(exec_d), .c_out(exec_c)
  );

  // Next-state: update only when enabled.
  always_comb begin
    acc_nxt = acc_q;
    c_nxt   = c_q;
    if (op_valid) begin
      acc_nxt = exec_d;
      c_nxt   = exec_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      acc_q <= '0;
      c_q   <= 1'b0;
    end else begin
      acc_q <= acc_nxt;
      c_q   <= c_nxt;
    end
  end

  acc_alu_cond #(.DW(DW)) u_cond (
    .code(br_code), .d(acc_q), .c(c_q), .flags(ext_flag), .taken(br_taken)
  );

  assign acc   = acc_q;
  assign carry = c_q;
endmodule

// File: rtl/acc_alu_chk.sv
`timescale 1ns/1ps
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [2:0]        alu_fn,
  input logic [DW-1:0]     operand,
  input logic [3:0]        br_code,
  input logic [FLAG_W-1:0] ext_flag,
  input logic [DW-1:0]     acc,
  input logic              carry,
  input logic              br_taken
);
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (acc == $past(acc)) && (carry == $past(carry)));

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && alu_fn == 3'd0) |=> (acc == $past(operand)) && (carry == $past(carry)));

  assert_logic_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && alu_fn inside {3'd1, 3'd2, 3'd3}) |=> carry == $past(carry));

  assert_add_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && alu_fn == 3'd4) |=>
      {carry, acc} == ({1'b0, $past(acc)} + {1'b0, $past(operand)}));

  assert_shr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && alu_fn == 3'd6) |=>
      (acc == ($past(acc) >> 1)) && (carry == $past(acc[0])));

  assert_always_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (br_code == 4'h0) |-> br_taken);

  assert_never_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (br_code == 4'h1 || br_code == 4'h8) |-> !br_taken);

  assert_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (br_code[3:2] == 2'b01) |-> (br_taken == ext_flag[br_code[1:0]]));
endmodule

bind acc_alu acc_alu_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n_sync), .op_valid(op_valid), .alu_fn(alu_fn),
  .operand(operand), .br_code(br_code), .ext_flag(ext_flag),
  .acc(acc), .carry(carry), .br_taken(br_taken)
);

// File: tb/sim_acc_alu.sv
`timescale 1ns/1ps
module sim_acc_alu;
  logic       clk, rst_n, op_valid;
  logic [2:0] alu_fn;
  logic [7:0] operand;
  logic [3:0] br_code, ext_flag;
  logic [7:0] acc;
  logic       carry, br_taken;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_acc;
  logic       m_c;
  logic [8:0] q_val[$];
  string      q_req[$];

  acc_alu u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .alu_fn(alu_fn),
    .operand(operand), .br_code(br_code), .ext_flag(ext_flag),
    .acc(acc), .carry(carry), .br_taken(br_taken)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // Monitor: one expected pair per driven cycle, due after the next rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q_val.size() > 0) begin
        logic [8:0] e;
        string r;
        e = q_val.pop_front();
        r = q_req.pop_front();
        checks++;
        if ({carry, acc} !== e) begin
          errors++;
          $display("FAIL %s carry/acc actual %0b/%02h expected %0b/%02h",
                   r, carry, acc, e[8], e[7:0]);
        end
      end
    end
  end

  function automatic string tag_of(input logic v, input logic [2:0] f);
    if (!v) return "R1";
    case (f)
      3'd0: return "R2";
      3'd1, 3'd2, 3'd3: return "R3";
      3'd4: return "R4";
      3'd5: return "R5";
      3'd6: return "R7";
      default: return "R6";
    endcase
  endfunction

  // Reference model written from the requirements.
  task automatic model(input logic v, input logic [2:0] f, input logic [7:0] m);
    logic [8:0] s;
    if (!v) return;
    case (f)
      3'd0: m_acc = m;
      3'd1: m_acc = m_acc | m;
      3'd2: m_acc = m_acc & m;
      3'd3: m_acc = m_acc ^ m;
      3'd4: begin s = {1'b0, m_acc} + {1'b0, m}; {m_c, m_acc} = s; end
      3'd5: begin s = {1'b0, m} + {1'b0, ~m_acc} + 9'd1; {m_c, m_acc} = s; end
      3'd6: begin m_c = m_acc[0]; m_acc = {1'b0, m_acc[7:1]}; end
      default: begin s = {1'b0, m_acc} + {1'b0, ~m} + 9'd1; {m_c, m_acc} = s; end
    endcase
  endtask

  task automatic drive(input logic v, input logic [2:0] f, input logic [7:0] m,
                       input string req);
    @(negedge clk);
    op_valid = v;
    alu_fn   = f;
    operand  = m;
    model(v, f, m);
    q_val.push_back({m_c, m_acc});
    q_req.push_back(req);
  endtask

  function automatic logic exp_br(input logic [3:0] c, input logic [3:0] fl,
                                  input logic [7:0] d, input logic cf);
    case (c)
      4'h0: return 1'b1;
      4'h2: return d == 8'h00;
      4'h3: return cf;
      4'h4, 4'h5, 4'h6, 4'h7: return fl[c - 4'h4];
      4'hA: return d != 8'h00;
      4'hB: return !cf;
      4'hC, 4'hD, 4'hE, 4'hF: return !fl[c - 4'hC];
      default: return 1'b0;
    endcase
  endfunction

  task automatic check_br(input logic [3:0] c, input logic [3:0] fl, input string req);
    logic e;
    drive(1'b0, 3'd0, 8'hA5, "R1");
    br_code  = c;
    ext_flag = fl;
    #2;
    e = exp_br(c, fl, m_acc, m_c);
    checks++;
    if (br_taken !== e) begin
      errors++;
      $display("FAIL %s br_code %h flags %b br_taken actual %0b expected %0b",
               req, c, fl, br_taken, e);
    end
  endtask

  initial begin
    logic [15:0] lfsr;
    rst_n    = 1'b0;
    op_valid = 1'b0;
    alu_fn   = 3'd0;
    operand  = 8'h00;
    br_code  = 4'h0;
    ext_flag = 4'h0;
    m_acc    = 8'h00;
    m_c      = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (acc !== 8'h00 || carry !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset carry/acc actual %0b/%02h expected 0/00", carry, acc);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Directed ALU sequence
    drive(1'b1, 3'd0, 8'h5A, "R2");
    drive(1'b1, 3'd1, 8'h0F, "R3");
    drive(1'b1, 3'd2, 8'hF0, "R3");
    drive(1'b1, 3'd3, 8'hFF, "R3");
    drive(1'b1, 3'd4, 8'h60, "R4");   // overflow: carry 1
    drive(1'b1, 3'd0, 8'h33, "R2");   // load keeps carry 1
    drive(1'b1, 3'd3, 8'h01, "R3");   // xor keeps carry 1
    drive(1'b1, 3'd4, 8'h02, "R4");   // no overflow: carry 0
    drive(1'b0, 3'd4, 8'hFF, "R1");   // idle: nothing changes
    drive(1'b1, 3'd6, 8'hFF, "R7");   // operand ignored
    drive(1'b1, 3'd0, 8'h81, "R2");
    drive(1'b1, 3'd6, 8'h00, "R7");   // 0x40, carry 1
    drive(1'b1, 3'd5, 8'h10, "R5");   // 0x10-0x40 borrow: carry 0
    drive(1'b1, 3'd7, 8'h10, "R6");   // 0xD0-0x10 no borrow: carry 1
    drive(1'b1, 3'd5, 8'hF0, "R5");   // 0xF0-0xC0 no borrow
    drive(1'b1, 3'd7, 8'h40, "R6");   // 0x30-0x40 borrow
    drive(1'b1, 3'd7, 8'hF0, "R6");   // 0xF0-0xF0 = 0, carry 1

    // Branch conditions
    check_br(4'h0, 4'h0, "R8");
    check_br(4'h1, 4'hF, "R8");
    check_br(4'h8, 4'hF, "R8");
    check_br(4'h2, 4'h0, "R9");       // acc is zero
    check_br(4'hA, 4'h0, "R9");
    check_br(4'h3, 4'h0, "R10");      // carry is 1
    check_br(4'hB, 4'h0, "R10");
    drive(1'b1, 3'd4, 8'h07, "R4");   // acc 7, carry 0
    check_br(4'h2, 4'h0, "R12");      // follows the update
    check_br(4'hA, 4'h0, "R12");
    check_br(4'h3, 4'h0, "R12");
    check_br(4'hB, 4'h0, "R10");
    for (int k = 0; k < 4; k++) begin
      check_br(4'h4 + 4'(k), 4'(1 << k), "R11");
      check_br(4'hC + 4'(k), 4'(1 << k), "R11");
      check_br(4'h4 + 4'(k), ~4'(1 << k), "R11");
      check_br(4'hC + 4'(k), ~4'(1 << k), "R11");
    end

    // Pseudo-random mix of operations and idle cycles
    lfsr = 16'hACE1;
    for (int i = 0; i < 200; i++) begin
      logic v;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      v = lfsr[11] | lfsr[12];
      drive(v, lfsr[2:0], lfsr[10:3], tag_of(v, lfsr[2:0]));
      if (i % 8 == 0) check_br(lfsr[15:12], lfsr[3:0], "R12");
    end

    drive(1'b0, 3'd0, 8'h00, "R1");
    repeat (3) @(posedge clk);
    #6;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule